// File: doc/BRIEF.md
# UART Receive Status and Interrupt Controller

This block is the register-side controller that sits between a UART's bit-level deserializer and a processor's register bus. The deserializer delivers each received byte on a one-cycle valid strobe, together with flags that mark noise, a bad stop bit or a parity mismatch. The controller keeps one received byte and a status register. It clears error flags through a two-step access: a status read that sees the flag set, followed by a data read. It also holds one byte for transmission and drives a single interrupt line from the enabled sources.

The overrun flag needs care. A byte that arrives while the held byte has not been read is dropped and sets overrun. From then on the receiver refuses every incoming byte until the two-step sequence clears the flag. If overrun sets after the status read has already been taken, the data read that follows does not clear it. Software must read status again and then read data.

Top module: `uart_stat_top`

## Requirements
- R1: After the active-low synchronous reset, status reads 0x40 (only transmit-empty set), control reads 0x00, `irq` is 0 and `txValid` is 0.
- R2: A byte taken on `rxValid` while receive-full is clear sets receive-full (status bit 7). A data read returns that byte and clears receive-full.
- R3: A byte that arrives while receive-full is set and no data read happens in that cycle is discarded and sets overrun (status bit 3). The held byte stays unchanged and readable.
- R4: Overrun clears only on a data read that follows a status read taken while overrun was already 1. A data read after a status read that saw overrun at 0 leaves it set.
- R5: While overrun is set, no incoming byte is accepted: receive-full stays clear and the held byte does not change.
- R6: Noise (bit 2), framing (bit 1) and parity (bit 0) are latched along with each accepted byte. Each one clears only through the same two-step sequence, so a data read with no status read before it leaves them set.
- R7: A byte that arrives in the same cycle as a data read is accepted without raising overrun, and the read returns the older byte.
- R8: A write to the data address clears transmit-empty (status bit 6) and presents the byte on `txData` with `txValid` high. When `txAck` is seen while `txValid` is high, transmit-empty sets again and `txValid` drops.
- R9: `irq` is the OR of three terms: receive-full AND control bit 0, transmit-empty AND control bit 1, overrun AND control bit 2.
- R10: Register map: status at address 0, control at address 1 (bits 2:0 read back), data at address 2. Status bits 5:4 read as 0. Read data is valid in the same cycle as the read. Its side effects take hold at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access in this cycle |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Register address |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, combinational from address |
| rxValid | input | 1 | Deserializer has a byte this cycle |
| rxByte | input | DATA_W | Received byte |
| rxNoise | input | 1 | Noise seen on this byte |
| rxFrame | input | 1 | Framing error on this byte |
| rxParity | input | 1 | Parity error on this byte |
| txData | output | DATA_W | Byte offered to the transmitter |
| txValid | output | 1 | Byte on txData is pending |
| txAck | input | 1 | Transmitter took the pending byte |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters: 8-bit registers, a 2-bit address and the status, control and data registers at addresses 0, 1 and 2. Narrow registers and three addresses let random traffic reach every flag combination often. This includes an overrun that lands in the same cycle as the status read. It also includes a byte that arrives in the same cycle as the data read that empties the register. Directed sequences pin down the exact status values around the two-step clear and the blocked receiver. Random traffic then checks every read and the interrupt and transmit outputs after every edge against a model built from the requirements.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
  // error flag indices; they are also the status bit positions
  localparam int ERR_PAR = 0;
  localparam int ERR_FRM = 1;
  localparam int ERR_NSE = 2;
  localparam int ERR_OVR = 3;
  localparam int NUM_ERR = 4;
  // other status bit positions
  localparam int ST_TXE = 6;
  localparam int ST_RXF = 7;
  // control register enable bits
  localparam int CT_RXIE = 0;
  localparam int CT_TXIE = 1;
  localparam int CT_OVIE = 2;
  localparam int NUM_IE  = 3;

  // strobes from control to datapath, all valid for one cycle
  typedef struct packed {
    logic statRd;
    logic dataRd;
    logic ctrlWr;
    logic dataWr;
    logic accept;
    logic overrunEv;
  } strobe_t;
endpackage

// File: rtl/uart_stat_ctrl.sv
module uart_stat_ctrl
  import uart_stat_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int STAT_ADDR = 0,
  parameter int CTRL_ADDR = 1,
  parameter int DATA_ADDR = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              rxValid,
  input  logic              rxFull,
  input  logic              ovrFlag,
  output strobe_t           strb
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_ADDR);

  logic rdCycle, wrCycle;

  always_comb begin
    rdCycle = busSel && !busWe;
    wrCycle = busSel && busWe;
    strb.statRd = rdCycle && (busAddr == A_STAT);
    strb.dataRd = rdCycle && (busAddr == A_DATA);
    strb.ctrlWr = wrCycle && (busAddr == A_CTRL);
    strb.dataWr = wrCycle && (busAddr == A_DATA);
    // a set overrun flag blocks the receiver entirely
    strb.accept    = rxValid && !ovrFlag && (!rxFull || strb.dataRd);
    strb.overrunEv = rxValid && !ovrFlag && rxFull && !strb.dataRd;
  end

  // R5: nothing is accepted while overrun is set
  a_r5_blocked_on_overrun: assert property (@(posedge clk) disable iff (!rstN)
    ovrFlag |-> !strb.accept);

  // R7: a byte is taken into a full register only alongside a data read
  a_r7_accept_needs_read: assert property (@(posedge clk) disable iff (!rstN)
    (strb.accept && rxFull) |-> strb.dataRd);

  // R10: at most one register access per cycle
  a_r10_one_access: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.statRd, strb.dataRd, strb.ctrlWr, strb.dataWr}));
endmodule

// File: rtl/uart_stat_dp.sv
module uart_stat_dp
  import uart_stat_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 2,
  parameter int STAT_ADDR = 0,
  parameter int CTRL_ADDR = 1,
  parameter int DATA_ADDR = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              rxNoise,
  input  logic              rxFrame,
  input  logic              rxParity,
  input  logic              txAck,
  output logic              rxFull,
  output logic              ovrFlag,
  output logic [DATA_W-1:0] txData,
  output logic              txValid,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_ADDR);

  logic               rxFullQ;
  logic [DATA_W-1:0]  rxDataQ;
  logic [NUM_ERR-1:0] errQ, errNext, armQ, armNext;
  logic [NUM_ERR-1:0] errLoad, errSet, errVal;
  logic               txEmptyQ;
  logic [DATA_W-1:0]  txBufQ;
  logic [NUM_IE-1:0]  ctrlQ;

  always_comb begin
    errVal          = '0;
    errVal[ERR_PAR] = rxParity;
    errVal[ERR_FRM] = rxFrame;
    errVal[ERR_NSE] = rxNoise;
  end

  // one flag plus arm bit per error; overrun is set by an event, the rest load with the byte
  for (genvar i = 0; i < NUM_ERR; i++) begin : g_err
    if (i == ERR_OVR) begin : g_ovr
      assign errLoad[i] = 1'b0;
      assign errSet[i]  = strb.overrunEv;
    end else begin : g_byte
      assign errLoad[i] = strb.accept;
      assign errSet[i]  = 1'b0;
    end
    assign errNext[i] = errLoad[i] ? errVal[i] :
                        errSet[i]  ? 1'b1 :
                        (strb.dataRd && armQ[i]) ? 1'b0 : errQ[i];
    assign armNext[i] = errNext[i] &
                        (strb.statRd ? errQ[i] :
                         (strb.dataRd || errLoad[i]) ? 1'b0 : armQ[i]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxFullQ  <= 1'b0;
      rxDataQ  <= '0;
      errQ     <= '0;
      armQ     <= '0;
      txEmptyQ <= 1'b1;
      txBufQ   <= '0;
      ctrlQ    <= '0;
    end else begin
      errQ <= errNext;
      armQ <= armNext;
      if (strb.accept) begin
        rxFullQ <= 1'b1;
        rxDataQ <= rxByte;
      end else if (strb.dataRd) begin
        rxFullQ <= 1'b0;
      end
      if (strb.dataWr) begin
        txEmptyQ <= 1'b0;
        txBufQ   <= busWdata;
      end else if (txAck && !txEmptyQ) begin
        txEmptyQ <= 1'b1;
      end
      if (strb.ctrlWr) ctrlQ <= busWdata[NUM_IE-1:0];
    end
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == A_STAT) begin
      busRdata[ST_RXF]        = rxFullQ;
      busRdata[ST_TXE]        = txEmptyQ;
      busRdata[NUM_ERR-1:0]   = errQ;
    end else if (busAddr == A_CTRL) begin
      busRdata = DATA_W'(ctrlQ);
    end else if (busAddr == A_DATA) begin
      busRdata = rxDataQ;
    end
  end

  assign rxFull  = rxFullQ;
  assign ovrFlag = errQ[ERR_OVR];
  assign txData  = txBufQ;
  assign txValid = !txEmptyQ;
  assign irq     = (rxFullQ & ctrlQ[CT_RXIE]) | (txEmptyQ & ctrlQ[CT_TXIE]) |
                   (errQ[ERR_OVR] & ctrlQ[CT_OVIE]);

  // R2: an accepted byte marks the register full
  a_r2_accept_fills: assert property (@(posedge clk) disable iff (!rstN)
    strb.accept |=> rxFullQ);

  // R3: an overrun event keeps the held byte and raises the flag
  a_r3_keep_held_byte: assert property (@(posedge clk) disable iff (!rstN)
    strb.overrunEv |=> (rxFullQ && $stable(rxDataQ) && errQ[ERR_OVR]));

  // R4: overrun falls only after an armed data read
  a_r4_overrun_clear_path: assert property (@(posedge clk) disable iff (!rstN)
    $fell(errQ[ERR_OVR]) |-> ($past(strb.dataRd) && $past(armQ[ERR_OVR])));

  // R8: an acknowledged byte is retired
  a_r8_tx_retire: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txAck && !strb.dataWr) |=> !txValid);

  // R9: no request without some enable
  a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (ctrlQ != '0));
endmodule

// File: rtl/uart_stat_top.sv
module uart_stat_top
  import uart_stat_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 2,
  parameter int STAT_ADDR = 0,
  parameter int CTRL_ADDR = 1,
  parameter int DATA_ADDR = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              rxNoise,
  input  logic              rxFrame,
  input  logic              rxParity,
  output logic [DATA_W-1:0] txData,
  output logic              txValid,
  input  logic              txAck,
  output logic              irq
);
  strobe_t strb;
  logic    rxFull, ovrFlag;

  uart_stat_ctrl #(
    .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .rxValid(rxValid), .rxFull(rxFull), .ovrFlag(ovrFlag), .strb(strb)
  );

  uart_stat_dp #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .STAT_ADDR(STAT_ADDR), .CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .rxByte(rxByte), .rxNoise(rxNoise), .rxFrame(rxFrame),
    .rxParity(rxParity), .txAck(txAck), .rxFull(rxFull), .ovrFlag(ovrFlag),
    .txData(txData), .txValid(txValid), .irq(irq)
  );
endmodule

// File: tb/sim_uart_stat_top.sv
module sim_uart_stat_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0, busWe = 1'b0;
  logic [1:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       rxValid = 1'b0;
  logic [7:0] rxByte = '0;
  logic       rxNoise = 1'b0, rxFrame = 1'b0, rxParity = 1'b0;
  logic [7:0] txData;
  logic       txValid;
  logic       txAck = 1'b0;
  logic       irq;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 0;

  // reference state, kept from the requirements
  logic       mRxFull, mTxEmpty;
  logic [7:0] mRxData, mTxBuf;
  logic [3:0] mErr, mArm;   // [3] overrun [2] noise [1] framing [0] parity
  logic [2:0] mCtrl;

  always #2 clk = ~clk;

  uart_stat_top u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .rxValid(rxValid), .rxByte(rxByte),
    .rxNoise(rxNoise), .rxFrame(rxFrame), .rxParity(rxParity), .txData(txData),
    .txValid(txValid), .txAck(txAck), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] modelRd(input int op);
    case (op)
      1:       return {mRxFull, mTxEmpty, 2'b00, mErr};
      2:       return {5'b0, mCtrl};
      default: return mRxData;
    endcase
  endfunction

  function automatic logic modelIrq();
    return (mRxFull & mCtrl[0]) | (mTxEmpty & mCtrl[1]) | (mErr[3] & mCtrl[2]);
  endfunction

  task automatic modelStep(input int op, input logic [7:0] wd, input logic rv,
                           input logic [7:0] rb, input logic [2:0] e, input logic ack);
    logic statRd, dataRd, acc, ovEv;
    logic [3:0] nErr, nArm;
    statRd = (op == 1);
    dataRd = (op == 3);
    acc  = rv && !mErr[3] && (!mRxFull || dataRd);
    ovEv = rv && !mErr[3] && mRxFull && !dataRd;
    for (int i = 0; i < 4; i++) begin
      logic ld;
      ld = (i < 3) && acc;
      if (ld) nErr[i] = e[i];
      else if (i == 3 && ovEv) nErr[i] = 1'b1;
      else if (dataRd && mArm[i]) nErr[i] = 1'b0;
      else nErr[i] = mErr[i];
      if (statRd) nArm[i] = mErr[i];
      else if (dataRd || ld) nArm[i] = 1'b0;
      else nArm[i] = mArm[i];
      nArm[i] = nArm[i] & nErr[i];
    end
    mErr = nErr;
    mArm = nArm;
    if (acc) begin mRxFull = 1'b1; mRxData = rb; end
    else if (dataRd) mRxFull = 1'b0;
    if (op == 5) begin mTxEmpty = 1'b0; mTxBuf = wd; end
    else if (ack && !mTxEmpty) mTxEmpty = 1'b1;
    if (op == 4) mCtrl = wd[2:0];
  endtask

  // op: 0 idle, 1 status read, 2 control read, 3 data read, 4 control write, 5 data write
  // e = {noise, framing, parity}; expRd < 0 takes the expected read value from the model
  task automatic doCycle(input int op, input logic [7:0] wd, input logic rv,
                         input logic [7:0] rb, input logic [2:0] e, input logic ack,
                         input int expRd, input string tag);
    logic [7:0] exp;
    @(negedge clk);
    busSel   = (op != 0);
    busWe    = (op >= 4);
    busAddr  = (op == 1) ? 2'd0 : (op == 2 || op == 4) ? 2'd1 : 2'd2;
    busWdata = wd;
    rxValid  = rv;
    rxByte   = rb;
    {rxNoise, rxFrame, rxParity} = e;
    txAck    = ack;
    #1;
    if (op >= 1 && op <= 3) begin
      exp = (expRd >= 0) ? expRd[7:0] : modelRd(op);
      chk(busRdata == exp, tag, busRdata, exp);
    end
    @(posedge clk);
    #1;
    modelStep(op, wd, rv, rb, e, ack);
    chk(irq == modelIrq(), "R9 irq", irq, modelIrq());
    chk(txValid == !mTxEmpty, "R8 txValid", txValid, !mTxEmpty);
    if (txValid) chk(txData == mTxBuf, "R8 txData", txData, mTxBuf);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nErrors++;
      $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not finish)");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    mRxFull = 0; mTxEmpty = 1; mRxData = 0; mTxBuf = 0; mErr = 0; mArm = 0; mCtrl = 0;
    void'($urandom(32'h5EED_0A17));
    repeat (4) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1;
    chk(irq == 1'b0, "R1 irq after reset", irq, 0);
    chk(txValid == 1'b0, "R1 txValid after reset", txValid, 0);
    doCycle(1, 0, 0, 0, 0, 0, 8'h40, "R1 status after reset");
    doCycle(2, 0, 0, 0, 0, 0, 8'h00, "R1 control after reset");

    // R2 plain receive
    doCycle(0, 0, 1, 8'hA5, 0, 0, -1, "");
    doCycle(1, 0, 0, 0, 0, 0, 8'hC0, "R2 full status");
    doCycle(3, 0, 0, 0, 0, 0, 8'hA5, "R2 data read");
    doCycle(1, 0, 0, 0, 0, 0, 8'h40, "R2 cleared status");

    // R3/R4 overrun with proper two-step clear
    doCycle(0, 0, 1, 8'h11, 0, 0, -1, "");
    doCycle(0, 0, 1, 8'h22, 0, 0, -1, "");
    doCycle(1, 0, 0, 0, 0, 0, 8'hC8, "R3 overrun status");
    doCycle(3, 0, 0, 0, 0, 0, 8'h11, "R3 held byte kept");
    doCycle(1, 0, 0, 0, 0, 0, 8'h40, "R4 overrun cleared");

    // R4/R5 overrun arrives during the status read: first data read does not clear it
    doCycle(0, 0, 1, 8'h33, 0, 0, -1, "");
    doCycle(1, 0, 1, 8'h44, 0, 0, 8'hC0, "R4 status before overrun");
    doCycle(3, 0, 0, 0, 0, 0, 8'h33, "R4 data read");
    doCycle(1, 0, 0, 0, 0, 0, 8'h48, "R4 overrun stays set");
    doCycle(0, 0, 1, 8'h55, 0, 0, -1, "");
    doCycle(1, 0, 0, 0, 0, 0, 8'h48, "R5 byte refused while overrun");
    doCycle(3, 0, 0, 0, 0, 0, 8'h33, "R5 held byte unchanged");
    doCycle(1, 0, 0, 0, 0, 0, 8'h40, "R4 second sequence clears");

    // R6 byte errors latched and cleared by two-step sequence
    doCycle(0, 0, 1, 8'h66, 3'b101, 0, -1, "");
    doCycle(3, 0, 0, 0, 0, 0, 8'h66, "R6 data read");
    doCycle(1, 0, 0, 0, 0, 0, 8'h45, "R6 flags survive unarmed read");
    doCycle(3, 0, 0, 0, 0, 0, 8'h66, "R6 armed data read");
    doCycle(1, 0, 0, 0, 0, 0, 8'h40, "R6 flags cleared");

    // R7 arrival during emptying read
    doCycle(0, 0, 1, 8'h77, 0, 0, -1, "");
    doCycle(3, 0, 1, 8'h78, 0, 0, 8'h77, "R7 read returns older byte");
    doCycle(1, 0, 0, 0, 0, 0, 8'hC0, "R7 no overrun");
    doCycle(3, 0, 0, 0, 0, 0, 8'h78, "R7 new byte kept");

    // R8 transmit handshake
    doCycle(5, 8'h9C, 0, 0, 0, 0, -1, "");
    chk(txValid && txData == 8'h9C, "R8 byte presented", txData, 8'h9C);
    doCycle(1, 0, 0, 0, 0, 0, 8'h00, "R8 tx-empty cleared");
    doCycle(0, 0, 0, 0, 0, 1, -1, "");
    chk(!txValid, "R8 ack retires byte", txValid, 0);
    doCycle(1, 0, 0, 0, 0, 0, 8'h40, "R8 tx-empty set again");

    // R9/R10 interrupt enables
    doCycle(4, 8'h02, 0, 0, 0, 0, -1, "");
    chk(irq == 1'b1, "R9 tx-empty irq", irq, 1);
    doCycle(2, 0, 0, 0, 0, 0, 8'h02, "R10 control readback");
    doCycle(4, 8'h01, 0, 0, 0, 0, -1, "");
    chk(irq == 1'b0, "R9 rx enable only, empty", irq, 0);
    doCycle(0, 0, 1, 8'hAB, 0, 0, -1, "");
    chk(irq == 1'b1, "R9 rx-full irq", irq, 1);
    doCycle(3, 0, 0, 0, 0, 0, 8'hAB, "R9 data read");
    chk(irq == 1'b0, "R9 irq drops after read", irq, 0);
    doCycle(4, 8'h04, 0, 0, 0, 0, -1, "");
    doCycle(0, 0, 1, 8'h01, 0, 0, -1, "");
    chk(irq == 1'b0, "R9 full without rx enable", irq, 0);
    doCycle(0, 0, 1, 8'h02, 0, 0, -1, "");
    chk(irq == 1'b1, "R9 overrun irq", irq, 1);
    doCycle(1, 0, 0, 0, 0, 0, 8'hC8, "R10 status layout");
    doCycle(3, 0, 0, 0, 0, 0, 8'h01, "R3 held byte");
    chk(irq == 1'b0, "R9 overrun irq cleared", irq, 0);
    doCycle(4, 8'h00, 0, 0, 0, 0, -1, "");

    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      int r, op;
      r  = $urandom_range(0, 9);
      op = (r < 3) ? 0 : (r < 5) ? 1 : (r < 7) ? 3 : (r == 7) ? 2 : (r == 8) ? 4 : 5;
      doCycle(op, 8'($urandom), ($urandom_range(0, 3) == 0), 8'($urandom),
              3'($urandom), 1'($urandom), -1,
              (op == 1) ? "R4 R6 R10 random status" :
              (op == 3) ? "R2 R3 R7 random data" : "R10 random control");
    end

    doCycle(0, 0, 0, 0, 0, 0, -1, "");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule